// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Monitor

This block watches the control pins of a four-bank double-data-rate SDRAM interface and turns each clock's pin pattern into one decoded command. Alongside the decode it keeps a small model of the memory: which banks have a row open, whether an auto-precharge write burst is still running, how long each bank still needs to finish precharging, and whether a mode-register load has just happened. Each command is checked against that model. A command that breaks a rule is reported with a code that names the broken rule.

The monitor is passive. It drives no memory pin. It sits next to a controller or a memory model in a larger design and reports, one cycle after each clock edge, the decoded command, the target bank and the verdict. A command that is flagged illegal does not change the tracked state. Burst length and precharge time are parameters.

Top module: `sdrm_monitor`

## Requirements
- R1: With both clock-enable samples high and chip select low, the RAS/CAS/WE levels decode as follows: LLL gives load-mode (code 2), LLH gives refresh (3), LHH gives activate (4), HLH gives read (5), HLL gives write (6), HHL gives burst stop (7), LHL gives precharge (8), or precharge-all (9) when the auto-precharge bit is high, and HHH gives no-op (0). Chip select high gives deselect (1). `cmd_o` shows the result one clock after the sampling edge.
- R2: Clock enable going high to low gives self-refresh entry (10) with the refresh pattern, and power-down entry (11) with a no-op pattern or with chip select high. Any other pattern gives malformed (14) with error code 7. Low to high gives exit (12). Low in both samples gives hold (13).
- R3: For activate, read, write and precharge, `bank_o` equals the two bank bits (0 to 3). For every other command it is 0, and that includes precharge-all, which ignores the bank bits and closes every bank.
- R4: An activate to a bank with an open row gives error 6. A read or write to a bank with no open row gives error 5. A legal activate opens the row, and a legal precharge closes it.
- R5: Load-mode, refresh and self-refresh entry give error 3 unless every bank is closed and no bank is still counting out its precharge time.
- R6: In the cycle right after a legal load-mode, any command other than no-op or deselect gives error 1.
- R7: After a legal write with auto-precharge, every read or write in the following BURST_LEN/2-1 cycles gives error 2.
- R8: A legal read or write with auto-precharge closes its bank. An activate to that bank gives error 4 until BURST_LEN/2+T_RP cycles after the access command. It is legal from that cycle on.
- R9: An illegal command leaves the bank state unchanged. Burst stop is always accepted.
- R10: A synchronous active-high reset closes all banks, clears all timers and sets the outputs to no-op, bank 0 and error 0.
- R11: When several rules are broken at once, the lowest nonzero error code is reported. `illegal_o` is high exactly when `err_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_prev | input | 1 | Clock enable sampled in the previous cycle |
| cke_cur | input | 1 | Clock enable sampled in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address bits |
| ap | input | 1 | Auto-precharge / precharge-all address bit |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank of the decoded command |
| illegal_o | output | 1 | High when the command breaks a rule |
| err_o | output | 3 | Code of the broken rule, 0 when legal |

## Verification
The bench builds the monitor with BURST_LEN=8 and T_RP=2. With these values the write-burst blocking window lasts three cycles and the precharge lockout lasts five. That leaves room to place a legal read to another bank inside the lockout and to probe the activate lockout both mid-window and on its last blocked cycle. The longer burst also allows a case where the burst-busy rule and the idle-bank rule apply together, which exercises the priority order.

// File: rtl/sdrm_mon_pkg.sv
package sdrm_mon_pkg;

  typedef enum logic [3:0] {
    SC_NOP       = 4'd0,
    SC_DESEL     = 4'd1,
    SC_LMODE     = 4'd2,
    SC_REFRESH   = 4'd3,
    SC_ACT       = 4'd4,
    SC_READ      = 4'd5,
    SC_WRITE     = 4'd6,
    SC_BSTOP     = 4'd7,
    SC_PRE       = 4'd8,
    SC_PRE_ALL   = 4'd9,
    SC_SELF_IN   = 4'd10,
    SC_PDOWN_IN  = 4'd11,
    SC_CKE_EXIT  = 4'd12,
    SC_CKE_HOLD  = 4'd13,
    SC_CKE_BAD   = 4'd14
  } sd_cmd_e;

  // Lower code = higher priority.
  typedef enum logic [2:0] {
    SE_NONE      = 3'd0,
    SE_LMODE_GAP = 3'd1,
    SE_WBURST    = 3'd2,
    SE_NOT_IDLE  = 3'd3,
    SE_TRP       = 3'd4,
    SE_BANK_SHUT = 3'd5,
    SE_BANK_BUSY = 3'd6,
    SE_CKE_BAD   = 3'd7
  } sd_err_e;

  // Cycles after a write-with-auto-precharge that still belong to its burst.
  function automatic int unsigned wburst_tail(int unsigned blen);
    return blen / 2 - 1;
  endfunction

  // Countdown loaded into a bank timer when an auto-precharge access is accepted.
  function automatic int unsigned ap_lockout(int unsigned blen, int unsigned trp);
    return blen / 2 - 1 + trp;
  endfunction

  function automatic int unsigned cnt_width(int unsigned maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/sdrm_cmd_decode.sv
module sdrm_cmd_decode
  import sdrm_mon_pkg::*;
(
  input  logic    cke_prev,
  input  logic    cke_cur,
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    ap,
  output sd_cmd_e cmd
);

  logic [2:0] rcw;
  assign rcw = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = SC_CKE_BAD;
    case ({cke_prev, cke_cur})
      2'b11: begin
        if (cs_n) begin
          cmd = SC_DESEL;
        end else begin
          case (rcw)
            3'b000:  cmd = SC_LMODE;
            3'b001:  cmd = SC_REFRESH;
            3'b011:  cmd = SC_ACT;
            3'b101:  cmd = SC_READ;
            3'b100:  cmd = SC_WRITE;
            3'b110:  cmd = SC_BSTOP;
            3'b010:  cmd = ap ? SC_PRE_ALL : SC_PRE;
            default: cmd = SC_NOP;
          endcase
        end
      end
      2'b10: begin
        if (cs_n || rcw == 3'b111) cmd = SC_PDOWN_IN;
        else if (rcw == 3'b001)    cmd = SC_SELF_IN;
        else                       cmd = SC_CKE_BAD;
      end
      2'b01:   cmd = SC_CKE_EXIT;
      default: cmd = SC_CKE_HOLD;
    endcase
  end

endmodule

// File: rtl/sdrm_bank_slot.sv
module sdrm_bank_slot
  import sdrm_mon_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic act_go,
  input  logic close_now,
  input  logic ap_load,
  output logic is_open,
  output logic trp_busy
);

  localparam int unsigned LOCK_N = ap_lockout(BURST_LEN, T_RP);
  localparam int unsigned TMR_W  = cnt_width(LOCK_N);

  logic             open_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      if (act_go)         open_q <= 1'b1;
      else if (close_now) open_q <= 1'b0;
      if (ap_load)            tmr_q <= TMR_W'(LOCK_N);
      else if (tmr_q != '0)   tmr_q <= tmr_q - TMR_W'(1);
    end
  end

  assign is_open  = open_q;
  assign trp_busy = (tmr_q != '0);

  AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(act_go && close_now)); // R4

  AST_TRP_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (trp_busy && !ap_load) |=> (tmr_q == $past(tmr_q) - TMR_W'(1))); // R8

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    act_go |=> is_open); // R4

endmodule

// File: rtl/sdrm_burst_guard.sv
module sdrm_burst_guard
  import sdrm_mon_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wburst_start,
  input  logic lmode_start,
  output logic wburst_busy,
  output logic lmode_hold
);

  localparam int unsigned TAIL_N = wburst_tail(BURST_LEN);
  localparam int unsigned CNT_W  = cnt_width(TAIL_N);

  logic [CNT_W-1:0] tail_q;
  logic             lm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
      lm_q   <= 1'b0;
    end else begin
      lm_q <= lmode_start;
      if (wburst_start)        tail_q <= CNT_W'(TAIL_N);
      else if (tail_q != '0)   tail_q <= tail_q - CNT_W'(1);
    end
  end

  assign wburst_busy = (tail_q != '0);
  assign lmode_hold  = lm_q;

  AST_LMODE_HOLD_SET: assert property (@(posedge clk) disable iff (rst)
    lmode_start |=> lmode_hold); // R6

  AST_LMODE_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
    (lmode_hold && !lmode_start) |=> !lmode_hold); // R6

endmodule

// File: rtl/sdrm_monitor.sv
module sdrm_monitor
  import sdrm_mon_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RP      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke_prev,
  input  logic       cke_cur,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       ap,
  output logic [3:0] cmd_o,
  output logic [1:0] bank_o,
  output logic       illegal_o,
  output logic [2:0] err_o
);

  localparam int unsigned NBANK  = 4;
  localparam int unsigned TAIL_N = wburst_tail(BURST_LEN);

  sd_cmd_e          cmd_c;
  sd_err_e          err_c;
  logic [NBANK-1:0] open_v, trp_v, act_go, close_now, ap_load;
  logic             wburst_busy, lmode_hold, ok_c;
  logic             is_access, needs_idle, quiet, all_idle, has_bank;
  logic             bank_open, bank_trp, wburst_start, lmode_start;

  sdrm_cmd_decode u_dec (
    .cke_prev(cke_prev), .cke_cur(cke_cur), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ap(ap), .cmd(cmd_c)
  );

  assign is_access  = (cmd_c == SC_READ) || (cmd_c == SC_WRITE);
  assign needs_idle = (cmd_c == SC_LMODE) || (cmd_c == SC_REFRESH) || (cmd_c == SC_SELF_IN);
  assign quiet      = (cmd_c == SC_NOP) || (cmd_c == SC_DESEL);
  assign has_bank   = is_access || (cmd_c == SC_ACT) || (cmd_c == SC_PRE);
  assign all_idle   = (open_v == '0) && (trp_v == '0);
  assign bank_open  = open_v[ba];
  assign bank_trp   = trp_v[ba];

  always_comb begin
    if (lmode_hold && !quiet)                 err_c = SE_LMODE_GAP;
    else if (wburst_busy && is_access)        err_c = SE_WBURST;
    else if (needs_idle && !all_idle)         err_c = SE_NOT_IDLE;
    else if (cmd_c == SC_ACT && bank_trp)     err_c = SE_TRP;
    else if (is_access && !bank_open)         err_c = SE_BANK_SHUT;
    else if (cmd_c == SC_ACT && bank_open)    err_c = SE_BANK_BUSY;
    else if (cmd_c == SC_CKE_BAD)             err_c = SE_CKE_BAD;
    else                                      err_c = SE_NONE;
  end

  assign ok_c         = (err_c == SE_NONE);
  assign wburst_start = ok_c && (cmd_c == SC_WRITE) && ap;
  assign lmode_start  = ok_c && (cmd_c == SC_LMODE);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit          = (ba == 2'(b));
    assign act_go[b]    = ok_c && (cmd_c == SC_ACT) && hit;
    assign ap_load[b]   = ok_c && is_access && ap && hit;
    assign close_now[b] = ok_c && (((cmd_c == SC_PRE) && hit) ||
                                   (cmd_c == SC_PRE_ALL) || (is_access && ap && hit));
    sdrm_bank_slot #(.BURST_LEN(BURST_LEN), .T_RP(T_RP)) u_slot (
      .clk(clk), .rst(rst), .act_go(act_go[b]), .close_now(close_now[b]),
      .ap_load(ap_load[b]), .is_open(open_v[b]), .trp_busy(trp_v[b])
    );
  end

  sdrm_burst_guard #(.BURST_LEN(BURST_LEN)) u_guard (
    .clk(clk), .rst(rst), .wburst_start(wburst_start), .lmode_start(lmode_start),
    .wburst_busy(wburst_busy), .lmode_hold(lmode_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o     <= SC_NOP;
      bank_o    <= '0;
      illegal_o <= 1'b0;
      err_o     <= SE_NONE;
    end else begin
      cmd_o     <= cmd_c;
      bank_o    <= has_bank ? ba : 2'd0;
      illegal_o <= !ok_c;
      err_o     <= err_c;
    end
  end

  AST_ONE_ACT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_go)); // R3

  AST_ACT_TO_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == SC_ACT && ok_c) |=> open_v[$past(ba)]); // R4

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (needs_idle && (open_v != '0)) |-> !ok_c); // R5

  AST_LMODE_GAP: assert property (@(posedge clk) disable iff (rst)
    lmode_start |=> (quiet || err_c == SE_LMODE_GAP)); // R6

  AST_WBURST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (wburst_start && TAIL_N > 0) |=> (!is_access || err_c == SE_WBURST)); // R7

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !ok_c |=> (open_v == $past(open_v))); // R9

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    illegal_o == (err_o != 3'd0)); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (open_v == '0 && !illegal_o && !wburst_busy)); // R10

endmodule

// File: tb/tb_sdrm_monitor.sv
module tb_sdrm_monitor;

  localparam int unsigned BL  = 8;
  localparam int unsigned TRP = 2;

  localparam logic [3:0] K_NOP = 0, K_DESEL = 1, K_LMODE = 2, K_REF = 3, K_ACT = 4,
                         K_RD = 5, K_WR = 6, K_BST = 7, K_PRE = 8, K_PREA = 9,
                         K_SELF = 10, K_PDN = 11, K_EXIT = 12, K_HOLD = 13, K_BAD = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke_prev = 1'b1, cke_cur = 1'b1, cs_n = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic       illegal_o;
  logic [2:0] err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sdrm_monitor #(.BURST_LEN(BL), .T_RP(TRP)) dut (
    .clk(clk), .rst(rst), .cke_prev(cke_prev), .cke_cur(cke_cur), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap),
    .cmd_o(cmd_o), .bank_o(bank_o), .illegal_o(illegal_o), .err_o(err_o)
  );

  task automatic check(input logic [3:0] ec, input logic [1:0] eb, input logic [2:0] ee,
                       input string tag);
    total++;
    if (cmd_o !== ec || bank_o !== eb || err_o !== ee || illegal_o !== (ee != 0)) begin
      bad++;
      $display("FAIL %s: cmd=%0d bank=%0d err=%0d ill=%0d expected cmd=%0d bank=%0d err=%0d ill=%0d",
               tag, cmd_o, bank_o, err_o, illegal_o, ec, eb, ee, (ee != 0));
    end
  endtask

  // Called at a falling edge; the result is visible at the next falling edge.
  task automatic send(input logic cp, input logic cc, input logic cs, input logic r,
                      input logic c, input logic w, input logic [1:0] b, input logic a);
    cke_prev = cp; cke_cur = cc; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; ap = a;
    @(negedge clk);
  endtask

  task automatic c_nop();                      send(1,1,0,1,1,1,2'd0,0); endtask
  task automatic c_act(input logic [1:0] b);   send(1,1,0,0,1,1,b,0);    endtask
  task automatic c_rd(input logic [1:0] b, input logic a); send(1,1,0,1,0,1,b,a); endtask
  task automatic c_wr(input logic [1:0] b, input logic a); send(1,1,0,1,0,0,b,a); endtask
  task automatic c_pre(input logic [1:0] b);   send(1,1,0,0,1,0,b,0);    endtask
  task automatic c_prea(input logic [1:0] b);  send(1,1,0,0,1,0,b,1);    endtask
  task automatic c_lmode();                    send(1,1,0,0,0,0,2'd0,0); endtask
  task automatic c_ref();                      send(1,1,0,0,0,1,2'd0,0); endtask

  task automatic do_reset();
    rst = 1'b1;
    send(1,1,1,1,1,1,2'd0,0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(K_NOP, 2'd0, 3'd0, "R10 outputs after reset");
  endtask

  task automatic t_decode();
    do_reset();
    c_nop();                  check(K_NOP,   2'd0, 3'd0, "R1 nop");
    send(1,1,1,0,0,0,2'd3,0); check(K_DESEL, 2'd0, 3'd0, "R1 deselect");
    send(1,1,0,1,1,0,2'd2,0); check(K_BST,   2'd0, 3'd0, "R1 R9 burst stop idle");
    c_ref();                  check(K_REF,   2'd0, 3'd0, "R1 refresh all idle");
    c_lmode();                check(K_LMODE, 2'd0, 3'd0, "R1 load mode");
    c_nop();                  check(K_NOP,   2'd0, 3'd0, "R6 nop after load mode");
  endtask

  task automatic t_banks();
    do_reset();
    c_act(2'd2);   check(K_ACT, 2'd2, 3'd0, "R3 activate bank 2");
    c_act(2'd2);   check(K_ACT, 2'd2, 3'd6, "R4 activate open bank");
    c_rd(2'd1, 0); check(K_RD,  2'd1, 3'd5, "R4 read idle bank");
    c_rd(2'd2, 0); check(K_RD,  2'd2, 3'd0, "R4 read open bank");
    c_wr(2'd2, 0); check(K_WR,  2'd2, 3'd0, "R4 write open bank");
    send(1,1,0,1,1,0,2'd1,0); check(K_BST, 2'd0, 3'd0, "R9 burst stop with open bank");
    c_pre(2'd2);   check(K_PRE, 2'd2, 3'd0, "R4 precharge bank 2");
    c_rd(2'd2, 0); check(K_RD,  2'd2, 3'd5, "R4 read after precharge");
    c_act(2'd1); c_act(2'd3);
    c_prea(2'd3);  check(K_PREA, 2'd0, 3'd0, "R3 precharge all ignores bank bits");
    c_wr(2'd1, 0); check(K_WR,  2'd1, 3'd5, "R3 bank 1 closed by precharge all");
    c_rd(2'd3, 0); check(K_RD,  2'd3, 3'd5, "R3 bank 3 closed by precharge all");
  endtask

  task automatic t_idle_rules();
    do_reset();
    c_act(2'd0);
    c_lmode();     check(K_LMODE, 2'd0, 3'd3, "R5 load mode with open bank");
    c_ref();       check(K_REF,   2'd0, 3'd3, "R5 refresh with open bank");
    send(1,0,0,0,0,1,2'd0,0); check(K_SELF, 2'd0, 3'd3, "R5 self refresh with open bank");
    c_prea(2'd0);
    send(1,0,0,0,0,1,2'd0,0); check(K_SELF, 2'd0, 3'd0, "R2 R5 self refresh when idle");
    send(0,1,1,1,1,1,2'd0,0); check(K_EXIT, 2'd0, 3'd0, "R2 clock enable exit");
  endtask

  task automatic t_lmode_gap();
    do_reset();
    c_lmode();     check(K_LMODE, 2'd0, 3'd0, "R6 load mode");
    c_act(2'd0);   check(K_ACT,   2'd0, 3'd1, "R6 command right after load mode");
    c_act(2'd0);   check(K_ACT,   2'd0, 3'd0, "R9 rejected activate left bank closed");
    c_lmode();     check(K_LMODE, 2'd0, 3'd3, "R9 activate took effect");
  endtask

  task automatic t_wburst();
    do_reset();
    c_act(2'd3); c_act(2'd1);
    c_wr(2'd3, 1); check(K_WR,  2'd3, 3'd0, "R7 write auto precharge");
    c_rd(2'd1, 0); check(K_RD,  2'd1, 3'd2, "R7 read in burst cycle 1");
    c_wr(2'd1, 0); check(K_WR,  2'd1, 3'd2, "R7 write in burst cycle 2");
    c_act(2'd3);   check(K_ACT, 2'd3, 3'd4, "R8 activate in lockout cycle 3");
    c_rd(2'd1, 0); check(K_RD,  2'd1, 3'd0, "R7 read after burst end");
    c_act(2'd3);   check(K_ACT, 2'd3, 3'd4, "R8 activate last blocked cycle");
    c_act(2'd3);   check(K_ACT, 2'd3, 3'd0, "R8 activate once lockout over");
  endtask

  task automatic t_priority();
    do_reset();
    c_act(2'd0);
    c_wr(2'd0, 1); check(K_WR, 2'd0, 3'd0, "R11 write auto precharge bank 0");
    c_rd(2'd2, 0); check(K_RD, 2'd2, 3'd2, "R11 burst rule beats idle-bank rule");
    c_ref();       check(K_REF, 2'd0, 3'd3, "R5 refresh during precharge lockout");
  endtask

  task automatic t_cke();
    do_reset();
    send(1,0,0,1,1,1,2'd0,0); check(K_PDN,  2'd0, 3'd0, "R2 power down by nop");
    send(0,0,1,1,1,1,2'd0,0); check(K_HOLD, 2'd0, 3'd0, "R2 clock enable held low");
    send(0,1,1,1,1,1,2'd0,0); check(K_EXIT, 2'd0, 3'd0, "R2 exit");
    send(1,0,1,0,1,1,2'd0,0); check(K_PDN,  2'd0, 3'd0, "R2 power down by deselect");
    send(1,0,0,0,1,1,2'd1,0); check(K_BAD,  2'd0, 3'd7, "R2 malformed clock enable fall");
  endtask

  task automatic t_reset_mid();
    do_reset();
    c_act(2'd1);
    do_reset();
    c_rd(2'd1, 0); check(K_RD, 2'd1, 3'd5, "R10 reset closes banks");
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_decode();
    t_banks();
    t_idle_rules();
    t_lmode_gap();
    t_wburst();
    t_priority();
    t_cke();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule